// File: doc/BRIEF.md
# Token-Steered BPSK/QPSK Symbol Mapper

The mapper turns a serial stream of coded bits into signed I/Q baseband samples. It takes no side-band mode select. The modulation is changed by control words that travel in the same input stream as the data bits. A mode change therefore takes effect on exactly the bit that follows the control word. In QPSK mode bits are taken in pairs. In BPSK mode each bit makes one sample and the quadrature rail stays at zero.

The mapper also takes part in a flush protocol. An abort control word is passed downstream and any half-built QPSK pair is discarded. Data words are then refused until the downstream stages raise a reconfiguration acknowledge. Control words that the mapper does not recognise leave in order with the surrounding samples. When the mapper is the last stage of a chain, it can be built to strip every control word so that only samples leave it.

Top module: `tok_iq_mapper`

## Requirements
- R1: After reset the mode is BPSK, no abort is pending, no QPSK half-pair is held, `out_valid` is 0 and `in_ready` is 1.
- R2: An input word with `in_is_ctrl`=0 is data, and its bit 0 is the coded bit. With `in_is_ctrl`=1 the whole word is an opcode: 0 selects BPSK, 1 selects QPSK, 2 is abort, and any other value is a foreign token.
- R3: Bit value 0 maps to +(2^(AMP_W-1)-1) and bit value 1 maps to its negative. In BPSK every data bit gives one sample with that value on I and 0 on Q.
- R4: In QPSK the first bit of each pair (the odd one, counting from 1) drives I and the second drives Q. One sample is produced per pair.
- R5: A mode word takes effect at its exact position in the stream. The mode word is consumed and never appears at the output.
- R6: If a mode word arrives while a QPSK half-pair is held, the held bit is first emitted as a BPSK sample (Q=0). The new mode applies only after that sample.
- R7: An abort word is forwarded as a token with opcode 2, and any held QPSK half-pair is discarded without output.
- R8: After an abort is taken, `in_ready` stays 0 for data words and 1 for control words (output permitting) until `reconf_ack` is seen high at a clock edge.
- R9: Foreign tokens leave unchanged, with I and Q at 0, in order between the samples around them.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output word is held stable and no input word is taken.
- R11: With STRIP_TOKENS=1 no token is ever presented at the output. Aborts still block data until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_is_ctrl | input | 1 | Tag: 1 = control word, 0 = data |
| in_word | input | WORD_W | Data bit in bit 0, or control opcode |
| reconf_ack | input | 1 | Downstream reconfiguration complete; clears a pending abort |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output |
| out_is_tok | output | 1 | Output word is a forwarded token |
| out_tok | output | WORD_W | Forwarded token opcode |
| out_i | output | AMP_W | Signed in-phase sample |
| out_q | output | AMP_W | Signed quadrature sample |

## Verification
The main instance uses the defaults: 8-bit words, 8-bit samples at ±127, and tokens forwarded. With these it covers mode switching at exact positions, the flush of a held half-pair, abort forwarding and output back-pressure. A second instance uses STRIP_TOKENS=1 and AMP_W=4. That instance covers the last-stage behaviour, where foreign and abort tokens vanish while data is still held back, and shows that the amplitude follows the width (±7).

// File: rtl/tok_iq_mapper.sv
module tok_iq_mapper #(
  parameter int WORD_W       = 8,
  parameter int AMP_W        = 8,
  parameter bit STRIP_TOKENS = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_is_ctrl,
  input  logic [WORD_W-1:0]       in_word,
  input  logic                    reconf_ack,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_is_tok,
  output logic [WORD_W-1:0]       out_tok,
  output logic signed [AMP_W-1:0] out_i,
  output logic signed [AMP_W-1:0] out_q
);
  localparam logic signed [AMP_W-1:0] AMP  = AMP_W'((1 << (AMP_W-1)) - 1);
  localparam logic signed [AMP_W-1:0] NAMP = -AMP;
  localparam logic [WORD_W-1:0] OP_BPSK  = WORD_W'(0);
  localparam logic [WORD_W-1:0] OP_QPSK  = WORD_W'(1);
  localparam logic [WORD_W-1:0] OP_ABORT = WORD_W'(2);

  logic mode_q, half_v, half_b, abort_pend;
  logic slot_free, take;
  logic emit, emit_tok;
  logic signed [AMP_W-1:0] emit_i, emit_q;

  function automatic logic signed [AMP_W-1:0] amp_of(input logic b);
    return b ? NAMP : AMP;
  endfunction

  assign slot_free = !out_valid || out_ready;
  assign in_ready  = slot_free && !(abort_pend && !in_is_ctrl);
  assign take      = in_valid && in_ready;

  always_comb begin
    emit     = 1'b0;
    emit_tok = 1'b0;
    emit_i   = '0;
    emit_q   = '0;
    if (!in_is_ctrl) begin
      if (!mode_q) begin
        emit   = 1'b1;
        emit_i = amp_of(in_word[0]);
      end else if (half_v) begin
        emit   = 1'b1;
        emit_i = amp_of(half_b);
        emit_q = amp_of(in_word[0]);
      end
    end else if (in_word == OP_BPSK || in_word == OP_QPSK) begin
      emit   = half_v;
      emit_i = amp_of(half_b);
    end else begin
      emit     = !STRIP_TOKENS;
      emit_tok = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      half_v     <= 1'b0;
      half_b     <= 1'b0;
      abort_pend <= 1'b0;
      out_valid  <= 1'b0;
      out_is_tok <= 1'b0;
      out_tok    <= '0;
      out_i      <= '0;
      out_q      <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (reconf_ack) abort_pend <= 1'b0;
      if (take) begin
        if (emit) begin
          out_valid  <= 1'b1;
          out_is_tok <= emit_tok;
          out_tok    <= emit_tok ? in_word : '0;
          out_i      <= emit_i;
          out_q      <= emit_q;
        end
        if (!in_is_ctrl) begin
          if (mode_q && !half_v) begin
            half_v <= 1'b1;
            half_b <= in_word[0];
          end else begin
            half_v <= 1'b0;
          end
        end else if (in_word == OP_BPSK || in_word == OP_QPSK) begin
          half_v <= 1'b0;
          mode_q <= (in_word == OP_QPSK);
        end else if (in_word == OP_ABORT) begin
          half_v     <= 1'b0;
          abort_pend <= 1'b1;
        end
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_is_tok, out_tok, out_i, out_q}));

  p_no_take_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_amp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_is_tok |-> (out_i == AMP || out_i == NAMP));

  p_tok_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_tok |-> (out_i == '0 && out_q == '0));

  p_block_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pend && in_valid && !in_is_ctrl |-> !in_ready);

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_ack && !(take && in_is_ctrl && in_word == OP_ABORT) |=> !abort_pend);

  p_bpsk_q0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && !in_is_ctrl && !mode_q |=> out_valid && out_q == '0);

  if (STRIP_TOKENS) begin : g_strip
    p_strip_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !out_is_tok);
  end else begin : g_fwd
    p_abort_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take && in_is_ctrl && in_word == OP_ABORT |=> out_valid && out_is_tok && out_tok == OP_ABORT);
  end
endmodule

// File: tb/tok_iq_mapper_tb.sv
module tok_iq_mapper_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic in_valid = 0, in_is_ctrl = 0, reconf_ack = 0, out_ready = 1;
  logic [7:0] in_word = '0;
  logic in_ready, out_valid, out_is_tok;
  logic [7:0] out_tok;
  logic signed [7:0] out_i, out_q;

  tok_iq_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_ctrl(in_is_ctrl), .in_word(in_word), .reconf_ack(reconf_ack),
    .out_valid(out_valid), .out_ready(out_ready), .out_is_tok(out_is_tok),
    .out_tok(out_tok), .out_i(out_i), .out_q(out_q));

  logic s_valid = 0, s_ctrl = 0, s_ack = 0;
  logic [7:0] s_word = '0;
  logic s_ready, s_ovalid, s_otok;
  logic [7:0] s_tokw;
  logic signed [3:0] s_i, s_q;

  tok_iq_mapper #(.WORD_W(8), .AMP_W(4), .STRIP_TOKENS(1'b1)) strip_i (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_ready(s_ready),
    .in_is_ctrl(s_ctrl), .in_word(s_word), .reconf_ack(s_ack),
    .out_valid(s_ovalid), .out_ready(1'b1), .out_is_tok(s_otok),
    .out_tok(s_tokw), .out_i(s_i), .out_q(s_q));

  int n_chk = 0, n_bad = 0;
  logic [24:0] cap [0:63];
  int ncap = 0;
  logic [16:0] scap [0:15];
  int nscap = 0;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && ncap < 64) begin
      cap[ncap] = {out_is_tok, out_tok, out_i, out_q};
      ncap++;
    end
    if (rst_n && s_ovalid && nscap < 16) begin
      scap[nscap] = {s_otok, s_tokw, s_i, s_q};
      nscap++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic c, input logic [7:0] w);
    @(negedge clk);
    in_valid = 1; in_is_ctrl = c; in_word = w;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic send_s(input logic c, input logic [7:0] w);
    @(negedge clk);
    s_valid = 1; s_ctrl = c; s_word = w;
    #1;
    while (!s_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    s_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // {ctrl, word}: D0 D1 Q D0 D1 D1 D1 D1 B D0 T5 D1 Q D0 D0
  localparam logic [8:0] STIM [0:14] = '{
    9'h000, 9'h001, 9'h101, 9'h000, 9'h001, 9'h001, 9'h001, 9'h001,
    9'h100, 9'h000, 9'h105, 9'h001, 9'h101, 9'h000, 9'h000};
  // {is_tok, tok, i, q}
  localparam logic [24:0] EXPV [0:8] = '{
    {1'b0, 8'h00, 8'h7F, 8'h00}, {1'b0, 8'h00, 8'h81, 8'h00},
    {1'b0, 8'h00, 8'h7F, 8'h81}, {1'b0, 8'h00, 8'h81, 8'h81},
    {1'b0, 8'h00, 8'h81, 8'h00}, {1'b0, 8'h00, 8'h7F, 8'h00},
    {1'b1, 8'h05, 8'h00, 8'h00}, {1'b0, 8'h00, 8'h81, 8'h00},
    {1'b0, 8'h00, 8'h7F, 8'h7F}};

  function automatic string tag_of(input int k);
    case (k)
      0, 1:    return "R3 bpsk";
      2, 3, 8: return "R4 qpsk pair";
      4:       return "R6 flush half";
      5:       return "R5 mode position";
      6:       return "R9 foreign token";
      default: return "R2 word format";
    endcase
  endfunction

  logic done = 0;
  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    idle(3);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 in_ready", 32'(in_ready), 1);

    for (int k = 0; k < 15; k++) send(STIM[k][8], STIM[k][7:0]);
    idle(3);
    check("R5 sample count", ncap, 9);
    for (int k = 0; k < 9; k++) check(tag_of(k), 32'(cap[k]), 32'(EXPV[k]));

    base = ncap;
    send(0, 8'h01);
    send(1, 8'h02);
    idle(3);
    check("R7 abort count", ncap, base + 1);
    check("R7 abort token", 32'(cap[base]), 32'({1'b1, 8'h02, 16'h0}));
    @(negedge clk); in_valid = 1; in_is_ctrl = 0; in_word = 8'h00; #1;
    check("R8 data refused", 32'(in_ready), 0);
    idle(4); #1;
    check("R8 still refused", 32'(in_ready), 0);
    in_valid = 0;
    send(1, 8'h07);
    idle(3);
    check("R8 ctrl accepted", 32'(cap[base + 1]), 32'({1'b1, 8'h07, 16'h0}));
    @(negedge clk); reconf_ack = 1;
    @(negedge clk); reconf_ack = 0;
    send(0, 8'h00);
    send(0, 8'h01);
    idle(3);
    check("R7 half discarded", 32'(cap[base + 2]), 32'({1'b0, 8'h00, 8'h7F, 8'h81}));

    base = ncap;
    @(negedge clk); out_ready = 0;
    send(0, 8'h00);
    send(0, 8'h00);
    idle(4); #1;
    check("R10 held valid", 32'(out_valid), 1);
    check("R10 held value", 32'({out_i, out_q}), 32'(16'h7F7F));
    in_valid = 1; in_is_ctrl = 0; #1;
    check("R10 no take", 32'(in_ready), 0);
    in_valid = 0;
    @(negedge clk); out_ready = 1;
    idle(3);
    check("R10 released", ncap, base + 1);

    send_s(0, 8'h01);
    send_s(1, 8'h05);
    send_s(1, 8'h02);
    @(negedge clk); s_valid = 1; s_ctrl = 0; s_word = 8'h00; #1;
    check("R11 strip blocks data", 32'(s_ready), 0);
    s_valid = 0;
    @(negedge clk); s_ack = 1;
    @(negedge clk); s_ack = 0;
    send_s(0, 8'h00);
    idle(3);
    check("R11 strip count", nscap, 2);
    check("R11 strip sample0", 32'(scap[0]), 32'({1'b0, 8'h00, 4'h9, 4'h0}));
    check("R11 strip sample1", 32'(scap[1]), 32'({1'b0, 8'h00, 4'h7, 4'h0}));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule